// File: doc/BRIEF.md
# Serial Divider Programming Port

This block is the programming front end for the dividers of a frequency synthesizer. Three wires reach it: a serial clock, serial data and a transfer enable. Every rising edge of the serial clock pushes one data bit into a single shared shift chain. A rising edge of the enable copies part of that chain into one of two groups of holding registers. The group is chosen by the last bit shifted in before the transfer. The holding registers drive the divider counters. Each group also raises a one-cycle strobe when it is rewritten, so the counters can reload.

The three wire inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and an extra register stage then finds its rising edges. All state is held in registers on the system clock. When the selector bit is 1, the 14 bits shifted in just before it go to the reference-divide register. When the selector bit is 0, the 17 bits shifted in before it are split between two registers. The first 10 bits go to the main-divide register and the next 7 go to the swallow-count register. In both cases the first bit shifted in is the most significant bit.

Top module: `synth_prog_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three divider registers, both strobes and the whole shift chain are cleared to zero.
- R2: Each rising edge of `ser_clk` shifts exactly one sample of `ser_data` into the chain. When `ser_clk` has no rising edge, the chain keeps its contents.
- R3: If the most recent bit shifted in is 1 when a transfer occurs, `ref_div` takes the 14 bits shifted in just before it. The earliest of those bits becomes bit 13.
- R4: If the most recent bit shifted in is 0 when a transfer occurs, the 17 bits before it are loaded. The earliest 10 go to `main_div`, earliest bit as bit 9. The next 7 go to `swallow_cnt`, earliest of those as bit 6.
- R5: While `ser_en` stays low, no divider register changes, however many bits are shifted in.
- R6: A transfer to one group leaves the registers of the other group unchanged.
- R7: `ref_loaded` or `main_loaded` is high for exactly one cycle, in the same cycle that its group's registers take new values. The two strobes are never high together.
- R8: A divider register shows its new value after the third rising system-clock edge, counting from the first edge that samples `ser_en` high. The two edges before that one leave it unchanged.
- R9: Holding `ser_en` high for many cycles causes only one transfer.
- R10: When more bits are shifted in than a load needs, only the most recently shifted bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_en | input | 1 | Transfer enable, rests low and is pulsed high |
| ref_div | output | 14 | Reference-divide register |
| main_div | output | 10 | Main-divide register |
| swallow_cnt | output | 7 | Swallow-count register |
| ref_loaded | output | 1 | One-cycle strobe when `ref_div` is written |
| main_loaded | output | 1 | One-cycle strobe when `main_div` and `swallow_cnt` are written |

## Verification
The assertions assume each level on `ser_clk` and `ser_en` lasts at least two system clocks, so that no edge is lost in the synchronizer. They also assume `ser_data` is steady for a few clocks around each rising `ser_clk`. The stimulus holds every level for three or four clocks. It changes `ser_data` only while `ser_clk` is low, and it never raises `ser_clk` and `ser_en` in the same cycle. Under these conditions the bench's reference model sees the same edges as the design, with the same latency, on every clock.

// File: rtl/synth_prog_pkg.sv
// Shared definitions for the serial divider programming port.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package synth_prog_pkg;

    // Default widths of the divider registers
    localparam int unsigned REF_W_DEF  = 14;
    localparam int unsigned MAIN_W_DEF = 10;
    localparam int unsigned SWAL_W_DEF = 7;
    localparam int unsigned SYNC_DEF   = 2;

    // Bit positions of the serial wires inside the synchronized vector
    typedef enum int unsigned {
        WIRE_CLK  = 0,
        WIRE_DATA = 1,
        WIRE_EN   = 2
    } wire_idx_e;

    localparam int unsigned WIRE_CNT = 3;

    // Larger of two widths
    function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sp_sync.sv
// Multi-bit synchronizer with one extra delay stage.
// dout is din after STAGES flops; dprev is dout one clock older and is used for edge detection.
// Assumes: each bit is an independent slow level. No bus coherence is needed.
module sp_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [W-1:0] stage_q [DEPTH];

    // Shift the samples through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout  = stage_q[STAGES-1];
    assign dprev = stage_q[STAGES];
endmodule

// File: rtl/sp_shift.sv
// Shared serial shift chain. Shifts one bit in at the LSB on each shift_en.
// The LSB always holds the most recently entered bit.
// Assumes: shift_en is a single-cycle pulse per serial clock edge.
module sp_shift #(
    parameter int unsigned CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          din,
    output logic [CW-1:0] chain
);
    // Empty on reset, shift left on each enable
    always_ff @(posedge clk) begin
        if (!rst_n)        chain <= '0;
        else if (shift_en) chain <= {chain[CW-2:0], din};
    end

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain));
    a_r2_one_bit_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain[0] == $past(din)) && (chain[CW-1:1] == $past(chain[CW-2:0])));
endmodule

// File: rtl/sp_latch.sv
// Divider holding registers. On xfer, the chain LSB (the selector bit) picks
// the reference group (1) or the main/swallow group (0). Emits a one-cycle strobe per group.
// Assumes: xfer is a single-cycle pulse; chain[0] is the last bit shifted in.
module sp_latch #(
    parameter int unsigned REF_W  = 14,
    parameter int unsigned MAIN_W = 10,
    parameter int unsigned SWAL_W = 7,
    parameter int unsigned CW     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [CW-1:0]     chain,
    output logic [REF_W-1:0]  ref_div,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic              ref_loaded,
    output logic              main_loaded
);
    localparam int unsigned MAIN_TOP = MAIN_W + SWAL_W;

    logic sel_ref;
    assign sel_ref = chain[0];

    // Reference group capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div    <= '0;
            ref_loaded <= 1'b0;
        end else begin
            ref_loaded <= xfer && sel_ref;
            if (xfer && sel_ref) ref_div <= chain[REF_W:1];
        end
    end

    // Main and swallow group capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_div    <= '0;
            swallow_cnt <= '0;
            main_loaded <= 1'b0;
        end else begin
            main_loaded <= xfer && !sel_ref;
            if (xfer && !sel_ref) begin
                main_div    <= chain[MAIN_TOP:SWAL_W+1];
                swallow_cnt <= chain[SWAL_W:1];
            end
        end
    end

    a_r3_ref_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && chain[0]) |=> (ref_div == $past(chain[REF_W:1])) && ref_loaded);
    a_r4_main_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !chain[0]) |=> (main_div == $past(chain[MAIN_TOP:SWAL_W+1]))
                               && (swallow_cnt == $past(chain[SWAL_W:1])) && main_loaded);
    a_r5_hold_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(ref_div) && $stable(main_div) && $stable(swallow_cnt));
    a_r6_ref_keeps_main: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && chain[0]) |=> $stable(main_div) && $stable(swallow_cnt) && !main_loaded);
    a_r6_main_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !chain[0]) |=> $stable(ref_div) && !ref_loaded);
endmodule

// File: rtl/synth_prog_port.sv
// Top level of the serial divider programming port.
// Synchronizes the three serial wires, detects their rising edges, shifts data
// into the shared chain and transfers it to the selected divider group.
// Assumes: serial levels last at least two system clocks.
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int unsigned REF_W  = REF_W_DEF,
    parameter int unsigned MAIN_W = MAIN_W_DEF,
    parameter int unsigned SWAL_W = SWAL_W_DEF,
    parameter int unsigned SYNC_N = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    output logic [REF_W-1:0]  ref_div,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic              ref_loaded,
    output logic              main_loaded
);
    localparam int unsigned CW = max_w(REF_W + 1, MAIN_W + SWAL_W + 1);

    logic [WIRE_CNT-1:0] wires, wires_s, wires_p;
    logic                clk_rise, en_rise;
    logic [CW-1:0]       chain;

    assign wires[WIRE_CLK]  = ser_clk;
    assign wires[WIRE_DATA] = ser_data;
    assign wires[WIRE_EN]   = ser_en;

    sp_sync #(.W(WIRE_CNT), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(wires), .dout(wires_s), .dprev(wires_p)
    );

    // Rising-edge pulses of the synchronized serial clock and enable
    always_comb begin
        clk_rise = wires_s[WIRE_CLK] && !wires_p[WIRE_CLK];
        en_rise  = wires_s[WIRE_EN]  && !wires_p[WIRE_EN];
    end

    sp_shift #(.CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(clk_rise),
        .din(wires_s[WIRE_DATA]), .chain(chain)
    );

    sp_latch #(.REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .CW(CW)) u_latch (
        .clk(clk), .rst_n(rst_n), .xfer(en_rise), .chain(chain),
        .ref_div(ref_div), .main_div(main_div), .swallow_cnt(swallow_cnt),
        .ref_loaded(ref_loaded), .main_loaded(main_loaded)
    );

    a_r9_single_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !en_rise);
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_loaded && main_loaded));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ref_div == '0) && (main_div == '0) && (swallow_cnt == '0)
                   && !ref_loaded && !main_loaded && (chain == '0));
endmodule

// File: tb/synth_prog_port_bench.sv
`timescale 1ns/1ps
module synth_prog_port_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
    logic [13:0] ref_div;
    logic [9:0]  main_div;
    logic [6:0]  swallow_cnt;
    logic        ref_loaded, main_loaded;

    int checks = 0, errors = 0;
    int ref_pulses = 0, main_pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    synth_prog_port u_synth_prog_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .ref_div(ref_div), .main_div(main_div), .swallow_cnt(swallow_cnt),
        .ref_loaded(ref_loaded), .main_loaded(main_loaded)
    );

    // Behavioural reference model: input history, bit queue, expected registers
    bit h_clk[3], h_dat[3], h_en[3];
    bit q[$];
    int m_ref = 0, m_main = 0, m_swal = 0;
    bit m_rl = 0, m_ml = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin h_clk[i] = 0; h_dat[i] = 0; h_en[i] = 0; end
            q.delete();
            for (int i = 0; i < 18; i++) q.push_back(1'b0);
            m_ref = 0; m_main = 0; m_swal = 0; m_rl = 0; m_ml = 0;
        end else begin
            m_rl = 0; m_ml = 0;
            if (h_en[1] && !h_en[2]) begin
                if (q[17]) begin
                    m_ref = 0;
                    for (int i = 0; i < 14; i++) m_ref = m_ref | (int'(q[16-i]) << i);
                    m_rl = 1;
                end else begin
                    m_main = 0; m_swal = 0;
                    for (int i = 0; i < 10; i++) m_main = m_main | (int'(q[9-i]) << i);
                    for (int i = 0; i < 7; i++)  m_swal = m_swal | (int'(q[16-i]) << i);
                    m_ml = 1;
                end
            end
            if (h_clk[1] && !h_clk[2]) begin
                q.push_back(h_dat[1]);
                void'(q.pop_front());
            end
            for (int i = 2; i > 0; i--) begin
                h_clk[i] = h_clk[i-1]; h_dat[i] = h_dat[i-1]; h_en[i] = h_en[i-1];
            end
            h_clk[0] = ser_clk; h_dat[0] = ser_data; h_en[0] = ser_en;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R8 latency, R2/R3/R4 contents), strobe counting
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ref_div == 14'(m_ref), "R8 model ref_div", int'(ref_div), m_ref);
            chk(main_div == 10'(m_main), "R8 model main_div", int'(main_div), m_main);
            chk(swallow_cnt == 7'(m_swal), "R8 model swallow_cnt", int'(swallow_cnt), m_swal);
            chk(ref_loaded == m_rl, "R7 model ref_loaded", int'(ref_loaded), int'(m_rl));
            chk(main_loaded == m_ml, "R7 model main_loaded", int'(main_loaded), int'(m_ml));
            if (ref_loaded)  ref_pulses++;
            if (main_loaded) main_pulses++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input bit b);
        ser_data = b; wait_n(3);
        ser_clk = 1'b1; wait_n(3);
        ser_clk = 1'b0; wait_n(3);
    endtask

    task automatic strobe();
        ser_en = 1'b1; wait_n(4);
        ser_en = 1'b0; wait_n(4);
    endtask

    task automatic shift_ref(input logic [13:0] v);
        for (int i = 13; i >= 0; i--) shift_bit(v[i]);
        shift_bit(1'b1);
    endtask

    task automatic shift_main(input logic [9:0] m, input logic [6:0] s);
        for (int i = 9; i >= 0; i--) shift_bit(m[i]);
        for (int i = 6; i >= 0; i--) shift_bit(s[i]);
        shift_bit(1'b0);
    endtask

    initial begin
        int rp, mp;
        wait_n(4);
        // R1: reset state
        chk(ref_div == 0 && main_div == 0 && swallow_cnt == 0, "R1 regs after reset",
            int'(ref_div) | int'(main_div) | int'(swallow_cnt), 0);
        chk(!ref_loaded && !main_loaded, "R1 strobes after reset", int'(ref_loaded | main_loaded), 0);
        rst_n = 1'b1; wait_n(2);

        // R3: reference load
        rp = ref_pulses; mp = main_pulses;
        shift_ref(14'h2A5B); strobe();
        chk(ref_div == 14'h2A5B, "R3 ref_div", int'(ref_div), 'h2A5B);
        chk(ref_pulses == rp + 1, "R7 one ref pulse", ref_pulses - rp, 1);
        chk(main_pulses == mp && main_div == 0 && swallow_cnt == 0, "R6 main untouched by ref",
            int'(main_div), 0);

        // R4: main/swallow load
        rp = ref_pulses; mp = main_pulses;
        shift_main(10'h2C3, 7'h55); strobe();
        chk(main_div == 10'h2C3, "R4 main_div", int'(main_div), 'h2C3);
        chk(swallow_cnt == 7'h55, "R4 swallow_cnt", int'(swallow_cnt), 'h55);
        chk(ref_div == 14'h2A5B && ref_pulses == rp, "R6 ref untouched by main", int'(ref_div), 'h2A5B);
        chk(main_pulses == mp + 1, "R7 one main pulse", main_pulses - mp, 1);

        // R2 and R5: shifting with enable low changes nothing
        shift_ref(14'h1111);
        chk(ref_div == 14'h2A5B && main_div == 10'h2C3, "R5 no change while enable low",
            int'(ref_div), 'h2A5B);
        // the chain held those bits: a strobe now shows the shifted word
        strobe();
        chk(ref_div == 14'h1111, "R2 chain kept shifted word", int'(ref_div), 'h1111);

        // R8: exact latency after the enable rises
        shift_ref(14'h3C0F);
        ser_en = 1'b1;
        wait_n(1);
        chk(ref_div == 14'h1111, "R8 unchanged after first edge", int'(ref_div), 'h1111);
        wait_n(1);
        chk(ref_div == 14'h1111 && !ref_loaded, "R8 unchanged after second edge", int'(ref_div), 'h1111);
        wait_n(1);
        chk(ref_div == 14'h3C0F && ref_loaded, "R8 updated after third edge", int'(ref_div), 'h3C0F);
        wait_n(1);
        chk(!ref_loaded, "R7 strobe lasts one cycle", int'(ref_loaded), 0);

        // R9: enable held high for a long time gives one transfer
        rp = ref_pulses;
        wait_n(40);
        ser_en = 1'b0; wait_n(4);
        chk(ref_pulses == rp, "R9 no repeat transfer", ref_pulses - rp, 0);

        // R10: excess leading bits are dropped
        for (int i = 0; i < 9; i++) shift_bit(1'b1);
        shift_main(10'h001, 7'h7E); strobe();
        chk(main_div == 10'h001 && swallow_cnt == 7'h7E, "R10 newest bits used",
            int'({main_div, swallow_cnt}), int'({10'h001, 7'h7E}));

        // R3 extremes: all ones, then all zeros with selector 1
        shift_ref(14'h3FFF); strobe();
        chk(ref_div == 14'h3FFF, "R3 all ones", int'(ref_div), 'h3FFF);
        shift_ref(14'h0000); strobe();
        chk(ref_div == 14'h0000, "R3 all zeros", int'(ref_div), 0);

        // R1: reset mid-operation clears everything
        shift_main(10'h3FF, 7'h7F); strobe();
        rst_n = 1'b0; wait_n(3);
        chk(ref_div == 0 && main_div == 0 && swallow_cnt == 0, "R1 reset clears regs",
            int'(main_div), 0);
        rst_n = 1'b1; wait_n(2);
        strobe();
        chk(main_div == 0 && swallow_cnt == 0 && main_loaded == 0, "R1 chain emptied by reset",
            int'(main_div), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule